// File: doc/BRIEF.md
# SPI ADC channel-scan controller

This block is an SPI master for a four-input successive-approximation converter. It builds each 16-bit outgoing frame from a channel number and a held settings register. It runs two kinds of operation. A single request converts one channel: one command frame goes out, then one separate read frame brings back the result. A scan trigger converts every channel enabled in a 4-bit mask. It first sends all the command frames in ascending channel order, then reads the same number of result frames in that order.

Every returned word carries a 4-bit channel tag above its 12 data bits. The controller compares this tag with the channel it expects for that slot. A matching word is presented with a one-cycle valid strobe. A word whose tag does not match is rejected: it raises an error strobe instead of the valid strobe. A done pulse marks the end of each operation. While an operation is running, any new request or trigger is dropped.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, chip select and the serial clock are high, busy, done, res_valid and res_err are low, and the settings are power mode 3, range bit 1 and binary-coding bit 1.
- R2: A command frame is the 12-bit control word shifted left by 4 and sent MSB first. Control bit 11 is 1. The channel sits in bits 7:6 and the power mode in bits 5:4. Range is bit 1 and coding is bit 0. The two sequence bits, control bits 10 and 3, are both 0. Bits 9:8 and 2 are 0. With reset settings, channel c gives frame 16'h8330 | (c << 10).
- R3: A cfg_wr pulse loads cfg_pm, cfg_range and cfg_binary. Every later command frame uses the new values.
- R4: A single request sends one command frame for single_chan, then one all-zero read frame. Chip select goes high between the two frames.
- R5: A scan sends one command frame for each enabled channel in ascending index order, then the same number of all-zero read frames. The k-th read frame is checked against the k-th enabled channel. Chip select goes high between every pair of frames.
- R6: The serial clock idles high and stays high while chip select is high. Each frame has exactly 16 rising edges, with a period of 2*HALF_DIV system clocks. The first MOSI bit is driven when chip select falls, and later bits change on falling edges. MISO is sampled on the rising edge.
- R7: Chip select stays high for at least 4*HALF_DIV system clocks (two serial clock periods) between frames.
- R8: When a read word's bits 15:12 equal the expected channel, res_valid pulses for one cycle. At the same time res_chan shows that channel and res_word shows the full 16-bit word.
- R9: When the tag does not match, res_valid stays low. res_err pulses instead, with res_chan set to the expected channel.
- R10: done pulses for one cycle after the last read frame, with busy low. A scan trigger with an all-zero mask raises done in the cycle after the trigger and makes no SPI activity.
- R11: A scan trigger or single request that arrives while busy is high is ignored. It adds no frames and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Load the settings inputs |
| cfg_pm | input | 2 | Power mode field for commands |
| cfg_range | input | 1 | Range select bit for commands |
| cfg_binary | input | 1 | Straight-binary coding bit for commands |
| single_req | input | 1 | Start a single-channel conversion |
| single_chan | input | 2 | Channel for the single conversion |
| scan_trig | input | 1 | Start a masked scan (wins over single_req) |
| scan_mask | input | 4 | Channel-enable mask for the scan |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| res_valid | output | 1 | Accepted result strobe |
| res_err | output | 1 | Rejected result (tag mismatch) strobe |
| res_chan | output | 2 | Channel of the current result |
| res_word | output | 16 | Returned word: tag 15:12, data 11:0 |

## Verification
One frame takes HALF_DIV lead cycles, then 32*HALF_DIV clock cycles, then HALF_DIV tail cycles, then 4*HALF_DIV cycles with chip select high. The result strobe for a read frame comes two cycles after its gap ends, and done follows one cycle after the last strobe. The zero-mask done is due exactly one cycle after the trigger edge. The bench models the converter as a slave fed from per-frame queues. On every falling system-clock edge it compares clock period, chip-select gap, result strobes and done against behavioural expectations. This way the checks follow frame boundaries and do not need hard-coded absolute cycle numbers, except for the zero-mask case.

// File: rtl/adcscan_pkg.sv
package adcscan_pkg;
   localparam int NCH     = 4;
   localparam int CH_W    = 2;
   localparam int TAG_W   = 4;
   localparam int FRAME_W = 16;
   localparam int CTRL_W  = 12;

   localparam logic [1:0] PM_RUN   = 2'd3;
   localparam logic [1:0] SEQ_NONE = 2'd0;

   typedef struct packed {
      logic [1:0] pm;
      logic       rng;
      logic       bin;
   } adc_cfg_t;

   // lowest enabled channel index
   function automatic logic [CH_W-1:0] first_set(input logic [NCH-1:0] m);
      logic [CH_W-1:0] r;
      r = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (m[i]) r = CH_W'(i);
      end
      return r;
   endfunction

   // control word; sequence code is split over bits 10 and 3
   function automatic logic [CTRL_W-1:0] ctrl_word(input logic [CH_W-1:0] ch,
                                                   input adc_cfg_t c,
                                                   input logic [1:0] seq);
      logic [CTRL_W-1:0] w;
      w      = '0;
      w[11]  = 1'b1;
      w[10]  = seq[1];
      w[7:6] = ch;
      w[5:4] = c.pm;
      w[3]   = seq[0];
      w[1]   = c.rng;
      w[0]   = c.bin;
      return w;
   endfunction
endpackage

// File: rtl/adcscan_settings.sv
module adcscan_settings
   import adcscan_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  adc_cfg_t            cfg_i,
   input  logic [CH_W-1:0]     ch_i,
   output logic [FRAME_W-1:0]  frame_o
);
   localparam int PAD_W = FRAME_W - CTRL_W;

   adc_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '{pm: PM_RUN, rng: 1'b1, bin: 1'b1};
      end else if (wr_i) begin
         cfg_q <= cfg_i;
      end
   end

   assign frame_o = {ctrl_word(ch_i, cfg_q, SEQ_NONE), {PAD_W{1'b0}}};

   // R3
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(cfg_q));
endmodule

// File: rtl/adcscan_frame_xfer.sv
module adcscan_frame_xfer #(
   parameter int HALF_DIV   = 2,
   parameter int GAP_HALVES = 4,
   parameter int W          = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] tx_i,
   output logic         fdone_o,
   output logic [W-1:0] rx_o,
   output logic         sclk_o,
   output logic         cs_n_o,
   output logic         mosi_o,
   input  logic         miso_i
);
   localparam int GAP_CYC = GAP_HALVES * HALF_DIV;
   localparam int CNT_W   = $clog2(GAP_CYC + 1);
   localparam int BIT_W   = $clog2(W);
   localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_DIV - 1);
   localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_CYC - 1);
   localparam logic [BIT_W-1:0] LAST    = BIT_W'(W - 1);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (GAP_HALVES < 4) begin : g_bad_gap
      $error("GAP_HALVES must be at least 4");
   end

   typedef enum logic [2:0] {X_IDLE, X_LEAD, X_LOW, X_HIGH, X_TAIL, X_GAP} xst_t;

   xst_t             st;
   logic [CNT_W-1:0] cnt;
   logic [BIT_W-1:0] bitn;
   logic [W-1:0]     tx_sh, rx_sh;
   logic             zero;

   assign zero   = (cnt == '0);
   assign mosi_o = tx_sh[W-1];
   assign rx_o   = rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= X_IDLE;
         cnt     <= '0;
         bitn    <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         sclk_o  <= 1'b1;
         cs_n_o  <= 1'b1;
         fdone_o <= 1'b0;
      end else begin
         fdone_o <= 1'b0;
         if (st != X_IDLE && !zero) begin
            cnt <= cnt - 1'b1;
         end
         case (st)
            X_IDLE: if (start_i) begin
               cs_n_o <= 1'b0;
               tx_sh  <= tx_i;
               bitn   <= '0;
               cnt    <= HALF_LD;
               st     <= X_LEAD;
            end
            X_LEAD: if (zero) begin
               sclk_o <= 1'b0;
               cnt    <= HALF_LD;
               st     <= X_LOW;
            end
            X_LOW: if (zero) begin
               sclk_o <= 1'b1;
               rx_sh  <= {rx_sh[W-2:0], miso_i};
               cnt    <= HALF_LD;
               st     <= X_HIGH;
            end
            X_HIGH: if (zero) begin
               cnt <= HALF_LD;
               if (bitn == LAST) begin
                  st <= X_TAIL;
               end else begin
                  sclk_o <= 1'b0;
                  tx_sh  <= tx_sh << 1;
                  bitn   <= bitn + 1'b1;
                  st     <= X_LOW;
               end
            end
            X_TAIL: if (zero) begin
               cs_n_o <= 1'b1;
               cnt    <= GAP_LD;
               st     <= X_GAP;
            end
            X_GAP: if (zero) begin
               fdone_o <= 1'b1;
               st      <= X_IDLE;
            end
            default: st <= X_IDLE;
         endcase
      end
   end

   // R6
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sclk_o);
   // R5
   cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> $past(start_i));
   // R7
   gap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fdone_o |-> (cs_n_o && $past(cs_n_o)));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adcscan_pkg::*;
#(
   parameter int HALF_DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [1:0]  cfg_pm,
   input  logic        cfg_range,
   input  logic        cfg_binary,
   input  logic        single_req,
   input  logic [1:0]  single_chan,
   input  logic        scan_trig,
   input  logic [3:0]  scan_mask,
   output logic        spi_sclk,
   output logic        spi_cs_n,
   output logic        spi_mosi,
   input  logic        spi_miso,
   output logic        busy,
   output logic        done,
   output logic        res_valid,
   output logic        res_err,
   output logic [1:0]  res_chan,
   output logic [15:0] res_word
);
   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} sst_t;

   sst_t               state;
   logic [NCH-1:0]     cmd_left, rd_left;
   logic [CH_W-1:0]    cur_ch, sel_ch;
   logic               cur_rd, sel_rd, start;
   logic [FRAME_W-1:0] cmd_frame, tx_word, rx_word;
   logic               fdone;
   adc_cfg_t           cfg_in;

   assign cfg_in = '{pm: cfg_pm, rng: cfg_range, bin: cfg_binary};
   assign sel_rd = (cmd_left == '0);
   assign sel_ch = first_set(sel_rd ? rd_left : cmd_left);
   assign start  = (state == S_ISSUE) && ((cmd_left | rd_left) != '0);
   assign tx_word = sel_rd ? '0 : cmd_frame;
   assign busy   = (state != S_IDLE);

   adcscan_settings i_settings (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cfg_wr),
      .cfg_i   (cfg_in),
      .ch_i    (sel_ch),
      .frame_o (cmd_frame)
   );

   adcscan_frame_xfer #(.HALF_DIV(HALF_DIV), .GAP_HALVES(4), .W(FRAME_W)) i_xfer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .tx_i    (tx_word),
      .fdone_o (fdone),
      .rx_o    (rx_word),
      .sclk_o  (spi_sclk),
      .cs_n_o  (spi_cs_n),
      .mosi_o  (spi_mosi),
      .miso_i  (spi_miso)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cmd_left  <= '0;
         rd_left   <= '0;
         cur_ch    <= '0;
         cur_rd    <= 1'b0;
         done      <= 1'b0;
         res_valid <= 1'b0;
         res_err   <= 1'b0;
         res_chan  <= '0;
         res_word  <= '0;
      end else begin
         done      <= 1'b0;
         res_valid <= 1'b0;
         res_err   <= 1'b0;
         case (state)
            S_IDLE: begin
               if (scan_trig) begin
                  if (scan_mask == '0) begin
                     done <= 1'b1;
                  end else begin
                     cmd_left <= scan_mask;
                     rd_left  <= scan_mask;
                     state    <= S_ISSUE;
                  end
               end else if (single_req) begin
                  cmd_left <= NCH'(1) << single_chan;
                  rd_left  <= NCH'(1) << single_chan;
                  state    <= S_ISSUE;
               end
            end
            S_ISSUE: begin
               if (start) begin
                  if (sel_rd) rd_left[sel_ch]  <= 1'b0;
                  else        cmd_left[sel_ch] <= 1'b0;
                  cur_ch <= sel_ch;
                  cur_rd <= sel_rd;
                  state  <= S_WAIT;
               end else begin
                  done  <= 1'b1;
                  state <= S_IDLE;
               end
            end
            S_WAIT: begin
               if (fdone) begin
                  if (cur_rd) begin
                     res_chan <= cur_ch;
                     res_word <= rx_word;
                     if (rx_word[FRAME_W-1 -: TAG_W] == TAG_W'(cur_ch)) res_valid <= 1'b1;
                     else                                               res_err   <= 1'b1;
                  end
                  state <= S_ISSUE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R11
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(scan_trig || single_req));
   // R9
   res_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid || res_err) |-> (busy && !(res_valid && res_err)));
   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && spi_cs_n));
   // R8
   res_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid || res_err) |-> spi_cs_n);
endmodule

// File: tb/test_adc_scan_ctrl.sv
module test_adc_scan_ctrl;
   localparam int HALF = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [1:0] cfg_pm = 2'd3;
   logic cfg_range = 1'b1, cfg_binary = 1'b1;
   logic single_req = 1'b0;
   logic [1:0] single_chan = 2'd0;
   logic scan_trig = 1'b0;
   logic [3:0] scan_mask = 4'd0;
   logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;
   logic busy, done, res_valid, res_err;
   logic [1:0] res_chan;
   logic [15:0] res_word;

   always #2 clk = ~clk;

   adc_scan_ctrl #(.HALF_DIV(HALF)) i_adc_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pm(cfg_pm),
      .cfg_range(cfg_range), .cfg_binary(cfg_binary),
      .single_req(single_req), .single_chan(single_chan),
      .scan_trig(scan_trig), .scan_mask(scan_mask),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .busy(busy), .done(done), .res_valid(res_valid), .res_err(res_err),
      .res_chan(res_chan), .res_word(res_word));

   int checks = 0, errors = 0, cyc = 0, frame_cnt = 0;
   logic [15:0] exp_tx_q[$], miso_q[$], exp_w_q[$];
   bit exp_err_q[$];
   int exp_ch_q[$];
   int b_pm = 3, b_rng = 1, b_bin = 1, seed = 5;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_cmd(input int ch);
      return 16'h8000 | 16'(ch << 10) | 16'(b_pm << 8) | 16'(b_rng << 5) | 16'(b_bin << 4);
   endfunction

   // converter model
   logic [15:0] cur_miso = 16'h0, got_mosi = 16'h0;
   int k = 16;
   assign spi_miso = (k < 16) ? cur_miso[15 - k] : 1'b0;

   always @(negedge spi_cs_n) if (rst_n) begin
      k = 0;
      got_mosi = 16'h0;
      cur_miso = (miso_q.size() > 0) ? miso_q.pop_front() : 16'hFFFF;
   end

   always @(posedge spi_sclk) if (rst_n && !spi_cs_n) begin
      got_mosi = {got_mosi[14:0], spi_mosi};
      k++;
   end

   always @(posedge spi_cs_n) if (rst_n) begin
      frame_cnt++;
      chk(k == 16, "R6 rising edges per frame", 32'(k), 32'd16);
      if (exp_tx_q.size() == 0) chk(1'b0, "R11 unexpected frame", {16'h0, got_mosi}, 32'h0);
      else begin
         logic [15:0] e;
         e = exp_tx_q.pop_front();
         chk(got_mosi == e, "R2/R4/R5 frame content", {16'h0, got_mosi}, {16'h0, e});
      end
   end

   // per-clock monitor
   logic prev_sclk = 1'b1, prev_cs = 1'b1;
   int last_rise = 0, cs_hi = 100;
   bit have_rise = 0, seen_frame = 0;

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
      if (rst_n) begin
         if (spi_cs_n && !spi_sclk) chk(1'b0, "R6 sclk low with cs high", 32'(spi_sclk), 32'd1);
         if (spi_sclk && !prev_sclk) begin
            if (have_rise) chk(cyc - last_rise == 2 * HALF, "R6 sclk period", 32'(cyc - last_rise), 32'(2 * HALF));
            have_rise = 1;
            last_rise = cyc;
         end
         if (!spi_cs_n && prev_cs) begin
            if (seen_frame) chk(cs_hi >= 4 * HALF, "R7 cs high gap", 32'(cs_hi), 32'(4 * HALF));
         end
         if (spi_cs_n && !prev_cs) begin
            cs_hi = 0;
            have_rise = 0;
            seen_frame = 1;
         end
         if (spi_cs_n) cs_hi++;
         if (res_valid || res_err) begin
            if (exp_ch_q.size() == 0) chk(1'b0, "R8 unexpected result", {16'h0, res_word}, 32'h0);
            else begin
               bit ee; int ec; logic [15:0] ew;
               ee = exp_err_q.pop_front(); ec = exp_ch_q.pop_front(); ew = exp_w_q.pop_front();
               if (ee) chk(res_err && !res_valid, "R9 tag mismatch flagged", {30'h0, res_err, res_valid}, 32'h2);
               else    chk(res_valid && !res_err, "R8 result accepted", {30'h0, res_err, res_valid}, 32'h1);
               chk(res_chan == 2'(ec), "R8 result channel", 32'(res_chan), 32'(ec));
               if (!ee) chk(res_word == ew, "R8 result word", 32'(res_word), 32'(ew));
            end
         end
      end
      prev_sclk = spi_sclk;
      prev_cs = spi_cs_n;
   end

   // one operation: is_scan selects scan (m = mask) or single (m[1:0] = channel)
   task automatic run_op(input bit is_scan, input logic [3:0] m, input int bad_ch, input bit inject);
      logic [3:0] en;
      int n, f0, t;
      bit got_done;
      en = is_scan ? m : (4'd1 << m[1:0]);
      n = 0;
      for (int c = 0; c < 4; c++) if (en[c]) begin
         exp_tx_q.push_back(exp_cmd(c));
         miso_q.push_back(16'h0);
         n++;
      end
      for (int c = 0; c < 4; c++) if (en[c]) begin
         logic [15:0] w;
         seed = seed + 97;
         w = {(c == bad_ch) ? 4'(c + 4) : 4'(c), 12'(seed * 13)};
         exp_tx_q.push_back(16'h0);
         miso_q.push_back(w);
         exp_err_q.push_back(c == bad_ch);
         exp_ch_q.push_back(c);
         exp_w_q.push_back(w);
      end
      f0 = frame_cnt;
      @(negedge clk);
      if (is_scan) begin scan_trig = 1; scan_mask = m; end
      else begin single_req = 1; single_chan = m[1:0]; end
      @(negedge clk);
      scan_trig = 0; single_req = 0;
      got_done = 0;
      for (t = 0; t < 6000 && !got_done; t++) begin
         @(negedge clk);
         if (inject && t == 60) begin scan_trig = 1; scan_mask = 4'hF; single_req = 1; end
         if (inject && t == 61) begin scan_trig = 0; single_req = 0; end
         if (done) got_done = 1;
      end
      chk(got_done, "R10 done pulse", 32'(got_done), 32'd1);
      chk(!busy, "R10 busy low at done", 32'(busy), 32'd0);
      chk(exp_ch_q.size() == 0, "R5 all results before done", 32'(exp_ch_q.size()), 32'd0);
      chk(frame_cnt - f0 == 2 * n, "R5 frame count", 32'(frame_cnt - f0), 32'(2 * n));
      repeat (40) begin
         @(negedge clk);
         if (done) chk(1'b0, "R11 extra done", 32'd1, 32'd0);
      end
      chk(frame_cnt - f0 == 2 * n && exp_tx_q.size() == 0, "R11 no frames after done",
          32'(frame_cnt - f0), 32'(2 * n));
   endtask

   task automatic load_cfg(input int pm, input int rng, input int bin);
      @(negedge clk);
      cfg_wr = 1; cfg_pm = 2'(pm); cfg_range = 1'(rng); cfg_binary = 1'(bin);
      @(negedge clk);
      cfg_wr = 0;
      b_pm = pm; b_rng = rng; b_bin = bin;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(spi_cs_n === 1'b1 && spi_sclk === 1'b1, "R1 spi idle", {30'h0, spi_cs_n, spi_sclk}, 32'h3);
      chk(busy === 1'b0 && done === 1'b0, "R1 busy/done low", {30'h0, busy, done}, 32'h0);
      chk(res_valid === 1'b0 && res_err === 1'b0, "R1 results low", {30'h0, res_valid, res_err}, 32'h0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      // R1 R2 R4: single conversion with reset settings
      run_op(0, 4'd2, -1, 0);
      // R5: scan, ascending order
      run_op(1, 4'b1011, -1, 0);
      // R9 and R11: full scan with one bad tag, requests injected while busy
      run_op(1, 4'b1111, 1, 1);
      // R3: new settings
      load_cfg(1, 0, 0);
      run_op(1, 4'b0100, -1, 0);
      load_cfg(2, 1, 0);
      run_op(0, 4'd3, -1, 0);
      run_op(1, 4'b1001, 3, 0);
      // R10: zero mask
      begin
         int f0;
         f0 = frame_cnt;
         @(negedge clk);
         scan_trig = 1; scan_mask = 4'd0;
         @(negedge clk);
         scan_trig = 0;
         chk(done === 1'b1, "R10 zero-mask done timing", 32'(done), 32'd1);
         chk(busy === 1'b0, "R10 zero-mask not busy", 32'(busy), 32'd0);
         @(negedge clk);
         chk(done === 1'b0, "R10 done one cycle", 32'(done), 32'd0);
         repeat (20) @(negedge clk);
         chk(frame_cnt == f0 && spi_cs_n, "R10 zero-mask no SPI", 32'(frame_cnt - f0), 32'd0);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule